// File: doc/BRIEF.md
# SPI Ready-Handshake Timeout Monitor

This block sits beside the shift engine of an SPI master that talks to a slave with a hardware handshake. On a five-wire link the slave drives an active-low ready line. The slave pulls ready active once it sees its chip select and releases it once it has taken in every bit of a word. The monitor watches the master's chip select, the slave's ready line, a one-cycle tick per SPI clock period, and word-start and word-end strobes from the shift engine. From these it judges whether the slave kept pace.

Two timeouts are counted in SPI clock ticks. The first limits how long the slave may take to assert ready after chip select goes active. The second limits how long the slave may keep ready asserted after chip select goes inactive. Holding ready too long shows that the slave missed clock edges and is still waiting for bits. Releasing ready while a word is still in flight is also desynchronisation. Each fault sets a sticky status flag, and a clear pulse lowers the flags. The ready line is asynchronous to the block clock and passes through a synchroniser before it is evaluated. The monitor only observes the link; it does not generate SPI data.

Top module: `spi_rdy_watchdog`

## Requirements
- R1: After reset, `rdy_tmo_flag` and `desync_flag` are both 0.
- R2: A session starts when `cs_n` is sampled low after being high. With limit L = `c2r_limit`, `rdy_tmo_flag` is set on the max(L,1)-th `sclk_tick` of the session if ready is still not seen active by then. Ready active means `rdy_n_async` = 0, seen after the two-flop synchroniser. Ready seen in the same cycle as that tick takes precedence, and no flag is set.
- R3: While `cs_timer_off` = 1, no ready timeout is raised, whatever the number of ticks.
- R4: Suppose ready was seen in a session and `cs_n` then rises. With limit L = `t2r_limit`, `desync_flag` is set on the max(L,1)-th `sclk_tick` after that rise if ready is still active then. Releasing ready before that tick raises no flag.
- R5: With `cs_n` low and ready seen, a word is in flight from a `word_start` pulse until the next `word_end` pulse. Ready seen inactive while a word is in flight sets `desync_flag`.
- R6: Ready released while `cs_n` is low but no word is in flight raises no flag.
- R7: Each flag stays 1 until a `flag_clr` pulse. The pulse makes it 0 on the next cycle unless a new fault of the same kind is detected in the same cycle.
- R8: Each new session restarts both tick counts from zero. Ticks counted in an aborted earlier session (one that `cs_n` rising ended before ready was seen) do not add to a later session.
- R9: While `mon_en` = 0, no fault is detected and the flags change only through `flag_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Monitoring enable (master mode with a ready-driving slave) |
| cs_timer_off | input | 1 | 1 disables the chip-select-to-ready timeout |
| flag_clr | input | 1 | One-cycle pulse that clears both flags |
| cs_n | input | 1 | Master chip select, active low, synchronous to clk |
| rdy_n_async | input | 1 | Slave ready line, active low, asynchronous |
| sclk_tick | input | 1 | One-cycle strobe per SPI clock period |
| word_start | input | 1 | Shift engine begins a word |
| word_end | input | 1 | Shift engine finished a word |
| c2r_limit | input | CW | Chip-select-to-ready limit in ticks |
| t2r_limit | input | CW | Chip-select-inactive-to-ready-release limit in ticks |
| rdy_tmo_flag | output | 1 | Sticky ready-timeout flag |
| desync_flag | output | 1 | Sticky desynchronisation flag |

## Verification
Both timeouts are swept over every pairing of a limit from 0 to 4 with a slave response after 0 to 5 ticks. This separates an off-by-one count, a limit-of-zero case that never fires, and a response that loses to the tick in the wrong order. Directed sessions then pair four behaviours with their look-alikes. Ready released during a word is compared with ready released between words. A timed-out session is compared with the same session under the timer-disable bit. A session aborted and restarted is compared with one long session. A disabled monitor is given the pattern that would otherwise fault. Sticky holding and clearing are checked after each fault.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_ARMED = 2'd2,
    PH_POST  = 2'd3
  } phase_e;

endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW:0]   cnt_inc;
  logic          step;

  assign step    = run & tick & ~clr;
  assign cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign expire  = step & (cnt_inc >= {1'b0, limit});

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                         cnt_d = '0;
    else if (step && cnt_q != CNT_MAX) cnt_d = cnt_inc[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rdy_phase_fsm.sv
module rdy_phase_fsm
  import spi_rdy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic timer_off,
  input  logic cs_n,
  input  logic rdy_act,
  input  logic word_start,
  input  logic word_end,
  input  logic c2r_exp,
  input  logic t2r_exp,
  output logic c2r_run,
  output logic c2r_clr,
  output logic t2r_run,
  output logic t2r_clr,
  output logic tmo_evt,
  output logic desync_evt
);

  phase_e phase_q, phase_d;
  logic   in_word_q, in_word_d;
  logic   cs_n_q;
  logic   cs_fall, cs_rise;

  assign cs_fall = cs_n_q & ~cs_n;
  assign cs_rise = ~cs_n_q & cs_n;

  // timer controls
  assign c2r_run = en & ~cs_fall & ~cs_rise & (phase_q == PH_WAIT) & ~rdy_act & ~timer_off;
  assign c2r_clr = ~en | cs_fall | (phase_q != PH_WAIT);
  assign t2r_run = en & ~cs_fall & (phase_q == PH_POST) & rdy_act;
  assign t2r_clr = ~en | cs_fall | (phase_q != PH_POST);

  always_comb begin
    phase_d    = phase_q;
    in_word_d  = in_word_q;
    tmo_evt    = 1'b0;
    desync_evt = 1'b0;
    if (!en) begin
      phase_d   = PH_IDLE;
      in_word_d = 1'b0;
    end else if (cs_fall) begin
      phase_d   = PH_WAIT;
      in_word_d = 1'b0;
    end else begin
      unique case (phase_q)
        PH_WAIT: begin
          if (cs_rise)      phase_d = PH_IDLE;
          else if (rdy_act) phase_d = PH_ARMED;
          else if (c2r_exp) begin
            tmo_evt = 1'b1;
            phase_d = PH_IDLE;
          end
        end
        PH_ARMED: begin
          if (cs_rise) begin
            phase_d   = PH_POST;
            in_word_d = 1'b0;
          end else if (in_word_q && !rdy_act) begin
            desync_evt = 1'b1;
            phase_d    = PH_IDLE;
            in_word_d  = 1'b0;
          end else begin
            if (word_start) in_word_d = 1'b1;
            if (word_end)   in_word_d = 1'b0;
          end
        end
        PH_POST: begin
          if (!rdy_act) phase_d = PH_IDLE;
          else if (t2r_exp) begin
            desync_evt = 1'b1;
            phase_d    = PH_IDLE;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      in_word_q <= 1'b0;
      cs_n_q    <= 1'b1;
    end else begin
      phase_q   <= phase_d;
      in_word_q <= in_word_d;
      cs_n_q    <= cs_n;
    end
  end

endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [NF-1:0] set,
  output logic [NF-1:0] flags
);

  logic [NF-1:0] flags_q;
  logic [NF-1:0] flags_d;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_comb begin
      flags_d[i] = set[i] | (flags_q[i] & ~clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

endmodule

// File: rtl/spi_rdy_watchdog.sv
module spi_rdy_watchdog #(
  parameter int CW        = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mon_en,
  input  logic          cs_timer_off,
  input  logic          flag_clr,
  input  logic          cs_n,
  input  logic          rdy_n_async,
  input  logic          sclk_tick,
  input  logic          word_start,
  input  logic          word_end,
  input  logic [CW-1:0] c2r_limit,
  input  logic [CW-1:0] t2r_limit,
  output logic          rdy_tmo_flag,
  output logic          desync_flag
);

  localparam int NFLAG = 2;

  logic             rdy_n_sync;
  logic             rdy_act;
  logic             c2r_run, c2r_clr, c2r_exp;
  logic             t2r_run, t2r_clr, t2r_exp;
  logic             rdy_tmo_evt, desync_evt;
  logic [NFLAG-1:0] flag_vec;

  rdy_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rdy_n_async),
    .dout  (rdy_n_sync)
  );

  assign rdy_act = ~rdy_n_sync;

  rdy_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (mon_en),
    .timer_off  (cs_timer_off),
    .cs_n       (cs_n),
    .rdy_act    (rdy_act),
    .word_start (word_start),
    .word_end   (word_end),
    .c2r_exp    (c2r_exp),
    .t2r_exp    (t2r_exp),
    .c2r_run    (c2r_run),
    .c2r_clr    (c2r_clr),
    .t2r_run    (t2r_run),
    .t2r_clr    (t2r_clr),
    .tmo_evt    (rdy_tmo_evt),
    .desync_evt (desync_evt)
  );

  tick_timer #(.CW(CW)) u_c2r (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (c2r_clr),
    .run    (c2r_run),
    .tick   (sclk_tick),
    .limit  (c2r_limit),
    .expire (c2r_exp)
  );

  tick_timer #(.CW(CW)) u_t2r (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (t2r_clr),
    .run    (t2r_run),
    .tick   (sclk_tick),
    .limit  (t2r_limit),
    .expire (t2r_exp)
  );

  sticky_flags #(.NF(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flag_clr),
    .set   ({desync_evt, rdy_tmo_evt}),
    .flags (flag_vec)
  );

  assign rdy_tmo_flag = flag_vec[0];
  assign desync_flag  = flag_vec[1];

endmodule

module spi_rdy_watchdog_chk (
  input logic clk,
  input logic rst_n,
  input logic mon_en,
  input logic cs_timer_off,
  input logic flag_clr,
  input logic cs_n,
  input logic rdy_tmo_evt,
  input logic desync_evt,
  input logic rdy_tmo_flag,
  input logic desync_flag
);

  assert_tmo_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_tmo_flag && !flag_clr |=> rdy_tmo_flag);

  assert_desync_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desync_flag && !flag_clr |=> desync_flag);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !rdy_tmo_evt && !desync_evt |=> !rdy_tmo_flag && !desync_flag);

  assert_timer_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_timer_off && !rdy_tmo_flag |=> !rdy_tmo_flag);

  assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en && !flag_clr |=> $stable(rdy_tmo_flag) && $stable(desync_flag));

  assert_tmo_in_session_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_tmo_evt |-> !cs_n);

endmodule

bind spi_rdy_watchdog spi_rdy_watchdog_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mon_en       (mon_en),
  .cs_timer_off (cs_timer_off),
  .flag_clr     (flag_clr),
  .cs_n         (cs_n),
  .rdy_tmo_evt  (rdy_tmo_evt),
  .desync_evt   (desync_evt),
  .rdy_tmo_flag (rdy_tmo_flag),
  .desync_flag  (desync_flag)
);

// File: tb/spi_rdy_watchdog_tb.sv
module spi_rdy_watchdog_tb;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mon_en = 1'b0;
  logic          cs_timer_off = 1'b0;
  logic          flag_clr = 1'b0;
  logic          cs_n = 1'b1;
  logic          rdy_n_async = 1'b1;
  logic          sclk_tick = 1'b0;
  logic          word_start = 1'b0;
  logic          word_end = 1'b0;
  logic [CW-1:0] c2r_limit = '0;
  logic [CW-1:0] t2r_limit = '0;
  logic          rdy_tmo_flag;
  logic          desync_flag;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  spi_rdy_watchdog #(.CW(CW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mon_en       (mon_en),
    .cs_timer_off (cs_timer_off),
    .flag_clr     (flag_clr),
    .cs_n         (cs_n),
    .rdy_n_async  (rdy_n_async),
    .sclk_tick    (sclk_tick),
    .word_start   (word_start),
    .word_end     (word_end),
    .c2r_limit    (c2r_limit),
    .t2r_limit    (t2r_limit),
    .rdy_tmo_flag (rdy_tmo_flag),
    .desync_flag  (desync_flag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) sclk_tick = 1'b1;
    @(negedge clk) sclk_tick = 1'b0;
    idle(2);
  endtask

  task automatic pulse_word_start();
    @(negedge clk) word_start = 1'b1;
    @(negedge clk) word_start = 1'b0;
  endtask

  task automatic pulse_word_end();
    @(negedge clk) word_end = 1'b1;
    @(negedge clk) word_end = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic end_session();
    cs_n = 1'b1;
    rdy_n_async = 1'b1;
    idle(5);
  endtask

  function automatic logic hits(input int lim, input int k);
    int eff;
    eff = (lim < 1) ? 1 : lim;
    return (k >= eff);
  endfunction

  task automatic run_all();
    // R1 reset state
    idle(3);
    check("R1 rdy_tmo after reset", rdy_tmo_flag, 1'b0);
    check("R1 desync after reset", desync_flag, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    mon_en = 1'b1;
    idle(3);

    // R2 sweep: chip-select-to-ready timeout
    t2r_limit = 8'd20;
    for (int lim = 0; lim <= 4; lim++) begin
      for (int k = 0; k <= 5; k++) begin
        clear_flags();
        c2r_limit = CW'(lim);
        cs_n = 1'b0;
        idle(2);
        repeat (k) tick();
        rdy_n_async = 1'b0;
        idle(4);
        check($sformatf("R2 c2r lim=%0d k=%0d", lim, k), rdy_tmo_flag, hits(lim, k));
        end_session();
      end
    end

    // R4 sweep: release after chip-select inactive
    c2r_limit = 8'd20;
    for (int lim = 0; lim <= 4; lim++) begin
      for (int k = 0; k <= 5; k++) begin
        clear_flags();
        t2r_limit = CW'(lim);
        cs_n = 1'b0;
        rdy_n_async = 1'b0;
        idle(4);
        pulse_word_start();
        idle(2);
        pulse_word_end();
        idle(2);
        cs_n = 1'b1;
        idle(2);
        repeat (k) tick();
        rdy_n_async = 1'b1;
        idle(4);
        check($sformatf("R4 t2r lim=%0d k=%0d", lim, k), desync_flag, hits(lim, k));
        end_session();
      end
    end

    // R7 sticky hold then clear
    clear_flags();
    t2r_limit = 8'd1;
    cs_n = 1'b0;
    rdy_n_async = 1'b0;
    idle(4);
    cs_n = 1'b1;
    idle(2);
    tick();
    rdy_n_async = 1'b1;
    idle(3);
    check("R4 desync after one tick", desync_flag, 1'b1);
    idle(20);
    check("R7 desync held", desync_flag, 1'b1);
    clear_flags();
    idle(1);
    check("R7 desync cleared", desync_flag, 1'b0);

    // R3 timer disabled
    t2r_limit = 8'd20;
    c2r_limit = 8'd1;
    cs_timer_off = 1'b1;
    cs_n = 1'b0;
    idle(2);
    repeat (4) tick();
    check("R3 no timeout while disabled", rdy_tmo_flag, 1'b0);
    rdy_n_async = 1'b0;
    idle(4);
    check("R3 no timeout after late ready", rdy_tmo_flag, 1'b0);
    end_session();
    cs_timer_off = 1'b0;

    // R5 early release during a word
    clear_flags();
    cs_n = 1'b0;
    rdy_n_async = 1'b0;
    idle(4);
    pulse_word_start();
    idle(2);
    rdy_n_async = 1'b1;
    idle(4);
    check("R5 early release desync", desync_flag, 1'b1);
    check("R5 no ready timeout", rdy_tmo_flag, 1'b0);
    end_session();

    // R6 release between words
    clear_flags();
    cs_n = 1'b0;
    rdy_n_async = 1'b0;
    idle(4);
    pulse_word_start();
    idle(2);
    pulse_word_end();
    idle(2);
    rdy_n_async = 1'b1;
    idle(5);
    check("R6 release between words", desync_flag, 1'b0);
    end_session();
    check("R6 no flag after session", desync_flag, 1'b0);

    // R8 restart of counting
    clear_flags();
    c2r_limit = 8'd3;
    cs_n = 1'b0;
    idle(2);
    repeat (2) tick();
    cs_n = 1'b1;
    idle(3);
    cs_n = 1'b0;
    idle(2);
    repeat (2) tick();
    rdy_n_async = 1'b0;
    idle(4);
    check("R8 count restarted", rdy_tmo_flag, 1'b0);
    end_session();
    cs_n = 1'b0;
    idle(2);
    repeat (3) tick();
    check("R8 full count times out", rdy_tmo_flag, 1'b1);
    end_session();

    // R9 monitor disabled
    clear_flags();
    idle(1);
    check("R7 ready timeout cleared", rdy_tmo_flag, 1'b0);
    mon_en = 1'b0;
    c2r_limit = 8'd1;
    cs_n = 1'b0;
    idle(2);
    repeat (3) tick();
    check("R9 no timeout while disabled", rdy_tmo_flag, 1'b0);
    rdy_n_async = 1'b0;
    idle(4);
    pulse_word_start();
    rdy_n_async = 1'b1;
    idle(4);
    check("R9 no desync while disabled", desync_flag, 1'b0);
    end_session();
    mon_en = 1'b1;
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected finished");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule